// File: doc/BRIEF.md
# Extension and Multiply-High Unit

This execution unit serves a small group of register-to-register operations. Each operation takes two 32-bit operands and returns one 32-bit result, which the surrounding pipeline writes back to the register named by operand a. Two families are handled.

The first family widens a narrow value taken from operand b, either a byte or a halfword, by sign or by zero extension. The second family returns only the upper half of the full 64-bit product of a and b. It has an unsigned form and a two's-complement signed form.

An operation is issued with a one-cycle `start` pulse together with its opcode and operands. Extensions finish on the next clock edge. Multiplies run a shift-and-add loop that retires one multiplier bit per cycle and hold `busy` while it runs. Completion is marked by a one-cycle `done`, and `result` then holds until the next completion. Three reserved opcodes next to the group raise a one-cycle `illegal` instead of `done`. The register file and the instruction decode sit outside the unit.

Top module: `xmul_ext_unit`

## Requirements
- R1: Opcode 0x10 returns bits [7:0] of opB sign-extended to 32 bits.
- R2: Opcode 0x11 returns bits [15:0] of opB sign-extended to 32 bits.
- R3: Opcode 0x12 returns bits [7:0] of opB zero-extended, and opcode 0x13 returns bits [15:0] of opB zero-extended.
- R4: An extension accepted at a clock edge raises `done` on that edge for exactly one cycle, and `busy` stays low throughout.
- R5: Opcode 0x14 returns bits [63:32] of the unsigned product opA times opB.
- R6: Opcode 0x15 returns bits [63:32] of the product of opA and opB, with both operands read as two's-complement signed values.
- R7: A multiply accepted at a clock edge holds `busy` high for exactly 32 cycles. `done` rises on the edge where `busy` falls and lasts one cycle.
- R8: `result` changes only on an edge that raises `done`, and it is stable in every cycle in which `done` is low.
- R9: Opcodes 0x16, 0x17 and 0x18 raise `illegal` for one cycle on the accepting edge. They do not raise `done` and leave `result` unchanged.
- R10: A `start` pulse that arrives while `busy` is high is ignored. The multiply in flight completes with its own result and latency, and no extra `done` follows.
- R11: Any opcode outside 0x10 to 0x18 is ignored: no `done`, no `illegal`, no `busy`, and `result` is unchanged.
- R12: While `rstN` is low, `busy`, `done` and `illegal` are low and `result` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Issue strobe, one cycle per operation |
| opcode | input | 8 | Operation code sampled with `start` |
| opA | input | 32 | Operand a (multiplicand) |
| opB | input | 32 | Operand b (extension source, multiplier) |
| busy | output | 1 | Multiply in progress |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | One-cycle reserved-opcode indication |
| result | output | 32 | Last completed result |

## Verification
The hardest case to reach from the ports is the signed high half. Its sign corrections only show up when one or both operands have the top bit set, and the worst cases are 0x80000000 and 0xFFFFFFFF. The stimulus crosses a fixed set of such edge operands in every pairing for both multiply forms, then adds random pairs. A second hard case is a `start` issued in the middle of a running multiply. The stimulus injects an extension request a few cycles into a multiply and then checks the latency and the result of the original operation.

// File: rtl/xmu_pkg.sv
package xmu_pkg;

  localparam int OPC_W = 8;

  localparam logic [OPC_W-1:0] OP_SEXT_B = 8'h10;
  localparam logic [OPC_W-1:0] OP_SEXT_H = 8'h11;
  localparam logic [OPC_W-1:0] OP_ZEXT_B = 8'h12;
  localparam logic [OPC_W-1:0] OP_ZEXT_H = 8'h13;
  localparam logic [OPC_W-1:0] OP_MULH_U = 8'h14;
  localparam logic [OPC_W-1:0] OP_MULH_S = 8'h15;
  localparam logic [OPC_W-1:0] OP_RSV_LO = 8'h16;
  localparam logic [OPC_W-1:0] OP_RSV_HI = 8'h18;

  // extKind: bit0 selects halfword source, bit1 selects zero fill
  typedef struct packed {
    logic       captureExt;
    logic [1:0] extKind;
    logic       loadMul;
    logic       stepMul;
    logic       finishMul;
    logic       signedMul;
  } xmu_strobe_t;

endpackage

// File: rtl/xmu_ctrl.sv
module xmu_ctrl
  import xmu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [OPC_W-1:0] opcode,
  output logic             busy,
  output logic             done,
  output logic             illegal,
  output xmu_strobe_t      strobe
);

  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(DATA_W - 1);

  logic             running;
  logic [CNT_W-1:0] stepCnt;
  logic             signedQ;
  logic             doneQ;
  logic             illegalQ;

  logic accept;
  logic isExt;
  logic isMul;
  logic isRsv;
  logic lastStep;

  always_comb begin
    accept   = start && !running;
    isExt    = (opcode >= OP_SEXT_B) && (opcode <= OP_ZEXT_H);
    isMul    = (opcode == OP_MULH_U) || (opcode == OP_MULH_S);
    isRsv    = (opcode >= OP_RSV_LO) && (opcode <= OP_RSV_HI);
    lastStep = running && (stepCnt == LAST_STEP);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      running  <= 1'b0;
      stepCnt  <= '0;
      signedQ  <= 1'b0;
      doneQ    <= 1'b0;
      illegalQ <= 1'b0;
    end else begin
      doneQ    <= (accept && isExt) || lastStep;
      illegalQ <= accept && isRsv;
      if (accept && isMul) begin
        running <= 1'b1;
        stepCnt <= '0;
        signedQ <= (opcode == OP_MULH_S);
      end else if (running) begin
        stepCnt <= stepCnt + 1'b1;
        if (lastStep) begin
          running <= 1'b0;
        end
      end
    end
  end

  always_comb begin
    strobe.captureExt = accept && isExt;
    strobe.extKind    = opcode[1:0];
    strobe.loadMul    = accept && isMul;
    strobe.stepMul    = running;
    strobe.finishMul  = lastStep;
    strobe.signedMul  = signedQ;
  end

  assign busy    = running;
  assign done    = doneQ;
  assign illegal = illegalQ;

endmodule

// File: rtl/xmu_dpath.sv
module xmu_dpath
  import xmu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  xmu_strobe_t       strobe,
  output logic [DATA_W-1:0] result
);

  localparam int BYTE_W = 8;
  localparam int HALF_W = 16;

  logic [DATA_W-1:0] mcandQ;
  logic [DATA_W-1:0] mplierQ;
  logic [DATA_W-1:0] prodHiQ;
  logic [DATA_W-1:0] prodLoQ;
  logic [DATA_W-1:0] resultQ;

  logic [DATA_W-1:0] addend;
  logic [DATA_W:0]   partial;
  logic [DATA_W-1:0] nextHi;
  logic [DATA_W-1:0] nextLo;
  logic [DATA_W-1:0] signFix;
  logic [DATA_W-1:0] mulOut;
  logic [DATA_W-1:0] extOut;

  // one multiplier bit per step: add, then shift the double-width pair right
  always_comb begin
    addend  = prodLoQ[0] ? mcandQ : '0;
    partial = {1'b0, prodHiQ} + {1'b0, addend};
    nextHi  = partial[DATA_W:1];
    nextLo  = {partial[0], prodLoQ[DATA_W-1:1]};
  end

  // a negative operand subtracts the other operand from the unsigned high half
  always_comb begin
    signFix = (mcandQ[DATA_W-1] ? mplierQ : '0)
            + (mplierQ[DATA_W-1] ? mcandQ : '0);
    mulOut  = strobe.signedMul ? (nextHi - signFix) : nextHi;
  end

  always_comb begin
    unique case (strobe.extKind)
      2'b00:   extOut = {{(DATA_W-BYTE_W){opB[BYTE_W-1]}}, opB[BYTE_W-1:0]};
      2'b01:   extOut = {{(DATA_W-HALF_W){opB[HALF_W-1]}}, opB[HALF_W-1:0]};
      2'b10:   extOut = {{(DATA_W-BYTE_W){1'b0}}, opB[BYTE_W-1:0]};
      default: extOut = {{(DATA_W-HALF_W){1'b0}}, opB[HALF_W-1:0]};
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mcandQ  <= '0;
      mplierQ <= '0;
      prodHiQ <= '0;
      prodLoQ <= '0;
    end else if (strobe.loadMul) begin
      mcandQ  <= opA;
      mplierQ <= opB;
      prodHiQ <= '0;
      prodLoQ <= opB;
    end else if (strobe.stepMul) begin
      prodHiQ <= nextHi;
      prodLoQ <= nextLo;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resultQ <= '0;
    end else if (strobe.captureExt) begin
      resultQ <= extOut;
    end else if (strobe.finishMul) begin
      resultQ <= mulOut;
    end
  end

  assign result = resultQ;

endmodule

// File: rtl/xmul_ext_unit.sv
module xmul_ext_unit
  import xmu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [OPC_W-1:0]  opcode,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  output logic              busy,
  output logic              done,
  output logic              illegal,
  output logic [DATA_W-1:0] result
);

  xmu_strobe_t strobe;

  xmu_ctrl #(.DATA_W(DATA_W)) ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .opcode  (opcode),
    .busy    (busy),
    .done    (done),
    .illegal (illegal),
    .strobe  (strobe)
  );

  xmu_dpath #(.DATA_W(DATA_W)) dpath_i (
    .clk    (clk),
    .rstN   (rstN),
    .opA    (opA),
    .opB    (opB),
    .strobe (strobe),
    .result (result)
  );

endmodule

// File: rtl/xmu_chk.sv
module xmu_chk
  import xmu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic [OPC_W-1:0]  opcode,
  input logic              busy,
  input logic              done,
  input logic              illegal,
  input logic [DATA_W-1:0] result
);

  localparam int CNT_W = $clog2(DATA_W) + 2;

  logic [CNT_W-1:0] busyCnt;

  always_ff @(posedge clk) begin
    if (!rstN)     busyCnt <= '0;
    else if (busy) busyCnt <= busyCnt + 1'b1;
    else           busyCnt <= '0;
  end

  // R4
  ext_single_cycle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy && opcode >= OP_SEXT_B && opcode <= OP_ZEXT_H) |=> (done && !busy));

  // R7
  mul_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (busyCnt == CNT_W'(DATA_W)));

  // R7
  mul_done_at_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);

  // R8
  result_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> $stable(result));

  // R9
  reserved_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy && opcode >= OP_RSV_LO && opcode <= OP_RSV_HI) |=> (illegal && !done));

  // R9
  illegal_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(illegal && done));

  // R10
  busy_origin_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(start));

  // R7
  done_excl_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(done && busy));

endmodule

bind xmul_ext_unit xmu_chk #(.DATA_W(DATA_W)) chk_i (
  .clk     (clk),
  .rstN    (rstN),
  .start   (start),
  .opcode  (opcode),
  .busy    (busy),
  .done    (done),
  .illegal (illegal),
  .result  (result)
);

// File: tb/xmul_ext_unit_tb_top.sv
module xmul_ext_unit_tb_top;

  localparam int W = 32;
  localparam int MAX_WAIT = W + 6;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         start = 1'b0;
  logic [7:0]   opcode = '0;
  logic [W-1:0] opA = '0;
  logic [W-1:0] opB = '0;
  logic         busy;
  logic         done;
  logic         illegal;
  logic [W-1:0] result;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  xmul_ext_unit #(.DATA_W(W)) dut_i (
    .clk(clk), .rstN(rstN), .start(start), .opcode(opcode),
    .opA(opA), .opB(opB), .busy(busy), .done(done),
    .illegal(illegal), .result(result)
  );

  task automatic check(input bit ok, input string req, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] refOp(input logic [7:0] op, input logic [W-1:0] a,
                                         input logic [W-1:0] b);
    logic [63:0]        pu;
    logic signed [63:0] sa, sb, ps;
    pu = {32'b0, a} * {32'b0, b};
    sa = $signed(a);
    sb = $signed(b);
    ps = sa * sb;
    case (op)
      8'h10:   return {{24{b[7]}}, b[7:0]};
      8'h11:   return {{16{b[15]}}, b[15:0]};
      8'h12:   return {24'b0, b[7:0]};
      8'h13:   return {16'b0, b[15:0]};
      8'h14:   return pu[63:32];
      default: return ps[63:32];
    endcase
  endfunction

  // drive at a falling edge; lat counts falling edges after the accepting edge
  task automatic runOp(input logic [7:0] op, input logic [W-1:0] a, input logic [W-1:0] b,
                       output int lat, output bit sawIll, output bit sawDone);
    start = 1'b1; opcode = op; opA = a; opB = b;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    sawIll = illegal;
    sawDone = done;
    while (!done && !illegal && lat < MAX_WAIT) begin
      @(negedge clk);
      lat++;
      sawIll = illegal;
      sawDone = done;
    end
  endtask

  task automatic testOp(input logic [7:0] op, input logic [W-1:0] a, input logic [W-1:0] b,
                        input string req);
    int lat; bit si, sd;
    logic [W-1:0] exp;
    exp = refOp(op, a, b);
    runOp(op, a, b, lat, si, sd);
    check(sd && result == exp, req, result, exp);
    if (op <= 8'h13)
      check(lat == 1 && !busy, "R4 ext latency", W'(lat), 1);
    else
      check(lat == W + 1, "R7 mul latency", W'(lat), W'(W + 1));
    @(negedge clk);
    check(!done, "R4/R7 done one cycle", W'(done), 0);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : stim
    logic [W-1:0] corners [8];
    logic [W-1:0] held;
    int lat; bit si, sd;
    corners[0] = 32'h0000_0000; corners[1] = 32'h0000_0001;
    corners[2] = 32'hFFFF_FFFF; corners[3] = 32'h8000_0000;
    corners[4] = 32'h7FFF_FFFF; corners[5] = 32'h8000_0001;
    corners[6] = 32'h0001_0000; corners[7] = 32'hDEAD_BEEF;

    repeat (3) @(negedge clk);
    // R12 reset state
    check(!busy && !done && !illegal && result == '0, "R12 reset", result, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R1 R2 R3 byte sweep with varying upper bits
    for (int v = 0; v < 256; v++) begin
      logic [W-1:0] b;
      b = {8'(v * 37), 8'(v ^ 8'h5A), 8'(255 - v), 8'(v)};
      testOp(8'h10, 32'h1234_5678, b, "R1 sext byte");
      testOp(8'h12, 32'h0, b, "R3 zext byte");
      b[15:8] = 8'(v);
      testOp(8'h11, 32'h0, b, "R2 sext half");
      testOp(8'h13, 32'h0, b, "R3 zext half");
    end

    // R5 R6 corner crosses
    for (int i = 0; i < 8; i++) begin
      for (int j = 0; j < 8; j++) begin
        testOp(8'h14, corners[i], corners[j], "R5 mulh unsigned corner");
        testOp(8'h15, corners[i], corners[j], "R6 mulh signed corner");
      end
    end

    // R5 R6 random
    for (int k = 0; k < 150; k++) begin
      logic [W-1:0] a, b;
      a = $urandom; b = $urandom;
      testOp(8'h14, a, b, "R5 mulh unsigned random");
      testOp(8'h15, a, b, "R6 mulh signed random");
    end

    // R9 reserved opcodes
    testOp(8'h15, 32'h8000_0000, 32'h8000_0000, "R6 setup");
    for (int op = 8'h16; op <= 8'h18; op++) begin
      held = result;
      runOp(8'(op), 32'h1, 32'hFFFF_FF80, lat, si, sd);
      check(si && !sd && lat == 1, "R9 illegal flag", W'(lat), 1);
      check(result == held, "R9 result unchanged", result, held);
      @(negedge clk);
      check(!illegal && !done, "R9 one-cycle flag", W'(illegal), 0);
    end

    // R11 out-of-group opcodes
    foreach (corners[i]) begin
      logic [7:0] op;
      op = (i % 2 == 0) ? 8'(8'h19 + i * 9) : 8'(8'h0F - i);
      held = result;
      runOp(op, 32'h3, 32'hFFFF_FFFF, lat, si, sd);
      check(!si && !sd && !busy && result == held, "R11 ignored opcode", result, held);
    end

    // R10 start during busy is ignored
    held = refOp(8'h14, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    start = 1'b1; opcode = 8'h14; opA = 32'hFFFF_FFFF; opB = 32'hFFFF_FFFF;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    start = 1'b1; opcode = 8'h10; opA = '0; opB = 32'h0000_0080;
    @(negedge clk);
    start = 1'b0;
    check(!done && busy, "R10 no early done", W'(done), 0);
    lat = 3;
    while (!done && lat < MAX_WAIT) begin
      @(negedge clk);
      lat++;
    end
    check(result == held, "R10 original result", result, held);
    check(lat == W + 1, "R10 original latency", W'(lat), W'(W + 1));
    repeat (3) begin
      @(negedge clk);
      check(!done && result == held, "R10 R8 no extra done", result, held);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule